// File: doc/BRIEF.md
# Exception Mode and Cause State Unit

This unit keeps the privileged exception state of a small processor core. A 16-bit status word holds a per-level interrupt mask and a three-entry stack of (user-mode, interrupt-enable) pairs. A cause word holds the pending bit for each interrupt level and the code of the last exception taken. A captured program counter records where control must return to.

Each cycle the unit decides whether the core must enter its exception handler. A synchronous event (fault, trap, system call) is always taken and carries its own code. An external interrupt is taken only when the current enable bit is set and an unmasked level is pending. When an exception is taken, the mode stack is pushed, which puts the handler in kernel mode with interrupts off. The cause code and the return address are recorded at the same time. A return strobe pops the stack. Software can load the status word and the return address, and can raise the software interrupt levels. The hardware pending bits follow the request lines alone.

Top module: `exc_state_unit`

## Requirements
- R1: After reset, status_o, cause_o and epc_o are all zero, user_o is 0 (kernel) and take_o is 0.
- R2: A software write with sel_i=0 loads status bits [15:8] and [5:0] from wdata_i; bits [7:6] always read 0. A write with sel_i=2 loads epc_o. user_o always equals status_o[1].
- R3: When sync_i is 1, take_o is 1 in the same cycle, whatever the enable and mask bits are.
- R4: On every taken exception, status bits [5:2] take the old bits [3:0] and bits [1:0] become 0, so the handler runs in kernel mode with interrupts disabled. The mask bits [15:8] keep their value.
- R5: A return strobe (rfe_i) with no exception in the same cycle moves status bits [5:2] into [3:0] and leaves [5:4] unchanged. If an exception is taken in the same cycle, the push wins.
- R6: A high level on hardware request line i sets cause bit 11+i one edge later. This happens while interrupts are disabled and when several lines rise together.
- R7: An interrupt is taken only when status bit 0 is 1 and (cause[15:8] AND status[15:8]) is nonzero. The mask bit that matches a pending bit sits at the same position.
- R8: The cause code field [5:2] takes code_i on a synchronous exception and 0 on an interrupt. A synchronous exception takes priority over an interrupt in the same cycle.
- R9: On a taken exception, epc_o captures pc_i.
- R10: A hardware pending bit clears only after an interrupt has been taken with that bit pending and unmasked, and then the line is seen low. If the line drops before service, the bit stays set.
- R11: A software write with sel_i=1 changes only cause bits [10:8] (the software levels). It has no effect on the hardware pending bits [15:11] or on the code field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 5 | Hardware interrupt request lines, level 0 in bit 0 |
| sync_i | input | 1 | Synchronous exception event |
| code_i | input | 4 | Code of the synchronous event |
| pc_i | input | 32 | Address of the instruction being executed or faulting |
| rfe_i | input | 1 | Return-from-exception strobe |
| wr_i | input | 1 | Software register write strobe |
| sel_i | input | 2 | Write target: 0 status, 1 cause, 2 return address |
| wdata_i | input | 32 | Software write data |
| take_o | output | 1 | Enter the exception handler this cycle |
| status_o | output | 16 | Status word |
| cause_o | output | 16 | Cause word |
| epc_o | output | 32 | Captured return address |
| user_o | output | 1 | Current mode, 1 for user |

## Verification
The hardest case to reach is the pending bit's service handshake. A request must be latched and then actually serviced before the line drops. The line must also drop while the handler's own push has cleared the enable, so that a second entry does not hide the clear. The stimulus holds the line through the taken cycle and releases it one edge later. A separate case releases the line while interrupts are still off and checks that the bit survives. A third case pulses a line with its mask bit clear and confirms that no entry happens. Nested entry and return sequences walk all three stack pairs, and one case raises the return strobe during a synchronous event.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NUM_HW   = 5;
  localparam int NUM_SW   = 3;
  localparam int NUM_LVL  = NUM_HW + NUM_SW;
  localparam int STACK_W  = 6;
  localparam int WORD_W   = 8 + NUM_LVL;
  localparam int CODE_W   = 4;
  localparam int CODE_LSB = 2;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2
  } wsel_e;

  localparam logic [CODE_W-1:0] CODE_EXT_INT = 4'd0;

  // entering a handler: every pair moves one level deeper, current pair is zeroed
  function automatic logic [STACK_W-1:0] stack_push(input logic [STACK_W-1:0] f);
    return {f[STACK_W-3:0], 2'b00};
  endfunction

  // leaving a handler: deeper pairs move up, the deepest pair is kept
  function automatic logic [STACK_W-1:0] stack_pop(input logic [STACK_W-1:0] f);
    return {f[STACK_W-1:STACK_W-2], f[STACK_W-1:2]};
  endfunction
endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
  import exc_pkg::*;
#(
  parameter int LVL = NUM_LVL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             wr_i,
  input  logic [7+LVL:0]   wdata_i,
  output logic [7+LVL:0]   status_o
);
  localparam int W = 8 + LVL;

  logic [LVL-1:0]     mask_q;
  logic [STACK_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      frame_q <= '0;
    end else if (push_i) begin
      frame_q <= stack_push(frame_q);
    end else if (pop_i) begin
      frame_q <= stack_pop(frame_q);
    end else if (wr_i) begin
      mask_q  <= wdata_i[W-1:8];
      frame_q <= wdata_i[STACK_W-1:0];
    end
  end

  assign status_o = {mask_q, 2'b00, frame_q};
endmodule

// File: rtl/exc_pending.sv
module exc_pending
  import exc_pkg::*;
#(
  parameter int HW = NUM_HW,
  parameter int SW = NUM_SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HW-1:0]    irq_i,
  input  logic             sw_wr_i,
  input  logic [SW-1:0]    sw_data_i,
  input  logic [HW-1:0]    service_i,
  output logic [HW+SW-1:0] pend_o,
  output logic [HW-1:0]    served_o
);
  logic [HW-1:0] hw_q;
  logic [HW-1:0] srv_q;
  logic [SW-1:0] sw_q;

  for (genvar i = 0; i < HW; i++) begin : g_hw
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hw_q[i]  <= 1'b0;
        srv_q[i] <= 1'b0;
      end else if (irq_i[i]) begin
        hw_q[i]  <= 1'b1;
        srv_q[i] <= srv_q[i] | service_i[i];
      end else if (srv_q[i]) begin
        hw_q[i]  <= 1'b0;
        srv_q[i] <= 1'b0;
      end else begin
        srv_q[i] <= service_i[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sw_q <= '0;
    else if (sw_wr_i) sw_q <= sw_data_i;
  end

  assign pend_o   = {hw_q, sw_q};
  assign served_o = srv_q;
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int LVL = NUM_LVL
) (
  input  logic           sync_i,
  input  logic           cur_en_i,
  input  logic [LVL-1:0] pend_i,
  input  logic [LVL-1:0] mask_i,
  output logic           take_o,
  output logic           int_take_o,
  output logic [LVL-1:0] live_o
);
  always_comb begin
    live_o     = pend_i & mask_i;
    int_take_o = !sync_i && cur_en_i && (|live_o);
    take_o     = sync_i || int_take_o;
  end
endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] irq_i,
  input  logic              sync_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              rfe_i,
  input  logic              wr_i,
  input  logic [1:0]        sel_i,
  input  logic [AW-1:0]     wdata_i,
  output logic              take_o,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] cause_o,
  output logic [AW-1:0]     epc_o,
  output logic              user_o
);
  logic                wr_status, wr_cause, wr_epc;
  logic                int_take;
  logic [NUM_LVL-1:0]  pend, live;
  logic [NUM_HW-1:0]   served, hw_service;
  logic [CODE_W-1:0]   code_q;
  logic [AW-1:0]       epc_q;

  assign wr_status = wr_i && (sel_i == SEL_STATUS);
  assign wr_cause  = wr_i && (sel_i == SEL_CAUSE);
  assign wr_epc    = wr_i && (sel_i == SEL_EPC);

  exc_arbiter #(.LVL(NUM_LVL)) u_arb (
    .sync_i     (sync_i),
    .cur_en_i   (status_o[0]),
    .pend_i     (pend),
    .mask_i     (status_o[WORD_W-1:8]),
    .take_o     (take_o),
    .int_take_o (int_take),
    .live_o     (live)
  );

  assign hw_service = int_take ? live[NUM_LVL-1:NUM_SW] : '0;

  exc_mode_stack #(.LVL(NUM_LVL)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_i   (take_o),
    .pop_i    (rfe_i),
    .wr_i     (wr_status),
    .wdata_i  (wdata_i[WORD_W-1:0]),
    .status_o (status_o)
  );

  exc_pending #(.HW(NUM_HW), .SW(NUM_SW)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_i     (irq_i),
    .sw_wr_i   (wr_cause),
    .sw_data_i (wdata_i[8+NUM_SW-1:8]),
    .service_i (hw_service),
    .pend_o    (pend),
    .served_o  (served)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      epc_q  <= '0;
    end else if (take_o) begin
      code_q <= sync_i ? code_i : CODE_EXT_INT;
      epc_q  <= pc_i;
    end else if (wr_epc) begin
      epc_q  <= wdata_i;
    end
  end

  assign cause_o = {pend, 2'b00, code_q, 2'b00};
  assign epc_o   = epc_q;
  assign user_o  = status_o[1];
endmodule

// File: rtl/exc_state_checker.sv
module exc_state_checker
  import exc_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_HW-1:0] irq_i,
  input logic              sync_i,
  input logic [CODE_W-1:0] code_i,
  input logic [AW-1:0]     pc_i,
  input logic              rfe_i,
  input logic              take_o,
  input logic [WORD_W-1:0] status_o,
  input logic [WORD_W-1:0] cause_o,
  input logic [AW-1:0]     epc_o
);
  a_r3_sync_taken: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |-> take_o);

  a_r4_push: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (status_o[1:0] == 2'b00) && (status_o[5:2] == $past(status_o[3:0]))
               && (status_o[15:8] == $past(status_o[15:8])));

  a_r5_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !take_o) |=> (status_o[3:0] == $past(status_o[5:2]))
                           && (status_o[5:4] == $past(status_o[5:4])));

  a_r6_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_i) |=> ((cause_o[15:11] & $past(irq_i)) == $past(irq_i)));

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !sync_i) |-> status_o[0]);

  a_r8_sync_code: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && sync_i) |=> (cause_o[5:2] == $past(code_i)));

  a_r8_int_code: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !sync_i) |=> (cause_o[5:2] == 4'd0));

  a_r9_epc: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> (epc_o == $past(pc_i)));

  a_r10_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cause_o[11]) |-> !irq_i[0]);
endmodule

bind exc_state_unit exc_state_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .sync_i(sync_i), .code_i(code_i),
  .pc_i(pc_i), .rfe_i(rfe_i), .take_o(take_o), .status_o(status_o),
  .cause_o(cause_o), .epc_o(epc_o)
);

// File: tb/tb_exc_state_unit.sv
module tb_exc_state_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  irq_i;
  logic        sync_i;
  logic [3:0]  code_i;
  logic [31:0] pc_i;
  logic        rfe_i;
  logic        wr_i;
  logic [1:0]  sel_i;
  logic [31:0] wdata_i;
  logic        take_o;
  logic [15:0] status_o, cause_o;
  logic [31:0] epc_o;
  logic        user_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_state_unit dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .sync_i(sync_i), .code_i(code_i),
    .pc_i(pc_i), .rfe_i(rfe_i), .wr_i(wr_i), .sel_i(sel_i), .wdata_i(wdata_i),
    .take_o(take_o), .status_o(status_o), .cause_o(cause_o), .epc_o(epc_o),
    .user_o(user_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance one edge; inputs change and outputs are sampled at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    irq_i = '0; sync_i = 0; code_i = '0; pc_i = '0; rfe_i = 0;
    wr_i = 0; sel_i = '0; wdata_i = '0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [31:0] d);
    wr_i = 1; sel_i = sel; wdata_i = d;
    step();
    wr_i = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", {16'h0, status_o}, 32'h0);
    chk("R1 cause", {16'h0, cause_o}, 32'h0);
    chk("R1 epc", epc_o, 32'h0);
    chk("R1 user", {31'h0, user_o}, 32'h0);
    chk("R1 take", {31'h0, take_o}, 32'h0);
  endtask

  task automatic t_sw_write();
    do_reset();
    sw_write(2'd0, 32'h0000_FFFF);
    chk("R2 status write", {16'h0, status_o}, 32'h0000_FF3F);
    chk("R2 user follows bit1", {31'h0, user_o}, 32'h1);
    sw_write(2'd2, 32'h1234_5678);
    chk("R2 epc write", epc_o, 32'h1234_5678);
  endtask

  task automatic t_nested();
    do_reset();
    sw_write(2'd0, 32'h0000_0003);
    sync_i = 1; code_i = 4'd8; pc_i = 32'h0000_0100;
    #1;
    chk("R3 take with sync", {31'h0, take_o}, 32'h1);
    step();
    chk("R4 first push", {16'h0, status_o}, 32'h0000_000C);
    chk("R8 sync code", {28'h0, cause_o[5:2]}, 32'd8);
    chk("R9 epc capture", epc_o, 32'h0000_0100);
    code_i = 4'd9; pc_i = 32'h0000_0200;
    #1;
    chk("R3 take while disabled", {31'h0, take_o}, 32'h1);
    step();
    sync_i = 0;
    chk("R4 second push", {16'h0, status_o}, 32'h0000_0030);
    chk("R9 epc second", epc_o, 32'h0000_0200);
    rfe_i = 1;
    step();
    chk("R5 first pop", {16'h0, status_o}, 32'h0000_003C);
    step();
    rfe_i = 0;
    chk("R5 second pop", {16'h0, status_o}, 32'h0000_003F);
    chk("R2 user after pop", {31'h0, user_o}, 32'h1);
  endtask

  task automatic t_push_beats_pop();
    do_reset();
    sw_write(2'd0, 32'h0000_0003);
    sync_i = 1; rfe_i = 1; code_i = 4'd12;
    step();
    sync_i = 0; rfe_i = 0;
    chk("R5 push wins over return", {16'h0, status_o}, 32'h0000_000C);
  endtask

  task automatic t_latch_disabled();
    do_reset();
    sw_write(2'd0, 32'h0000_1802);
    irq_i = 5'b00011;
    step();
    irq_i = '0;
    step(); step();
    chk("R6 two lines latched while off", {27'h0, cause_o[15:11]}, 32'h3);
    chk("R7 no take while disabled", {31'h0, take_o}, 32'h0);
    sw_write(2'd1, 32'h0000_0000);
    chk("R11 hw pending ignores write", {27'h0, cause_o[15:11]}, 32'h3);
    sw_write(2'd1, 32'h0000_FF3C);
    chk("R11 only sw bits written", {16'h0, cause_o}, 32'h0000_1F00);
    sw_write(2'd1, 32'h0000_0000);
    chk("R10 unserved bit stays", {27'h0, cause_o[15:11]}, 32'h3);
    wdata_i = 32'h0000_0801; wr_i = 1; sel_i = 2'd0;
    step();
    wr_i = 0;
    #1;
    chk("R7 take once enabled", {31'h0, take_o}, 32'h1);
    pc_i = 32'h0000_0440;
    step();
    chk("R8 interrupt code zero", {28'h0, cause_o[5:2]}, 32'd0);
    chk("R9 epc on interrupt", epc_o, 32'h0000_0440);
    step();
    chk("R10 served bit clears, unmasked stays", {27'h0, cause_o[15:11]}, 32'h2);
  endtask

  task automatic t_masked();
    do_reset();
    sw_write(2'd0, 32'h0000_0801);
    irq_i = 5'b00100;
    step();
    #1;
    chk("R7 masked level not taken", {31'h0, take_o}, 32'h0);
    chk("R6 masked level still pending", {31'h0, cause_o[13]}, 32'h1);
    irq_i = '0;
  endtask

  task automatic t_service_handshake();
    do_reset();
    sw_write(2'd0, 32'h0000_0803);
    irq_i = 5'b00001; pc_i = 32'h0000_0800;
    step();
    #1;
    chk("R7 take on unmasked pending", {31'h0, take_o}, 32'h1);
    step();
    chk("R4 push on interrupt", {16'h0, status_o}, 32'h0000_080C);
    chk("R10 held while line high", {31'h0, cause_o[11]}, 32'h1);
    step();
    chk("R10 still held", {31'h0, cause_o[11]}, 32'h1);
    irq_i = '0;
    step();
    chk("R10 cleared after release", {31'h0, cause_o[11]}, 32'h0);
  endtask

  task automatic t_sync_priority();
    do_reset();
    sw_write(2'd0, 32'h0000_0801);
    irq_i = 5'b00001;
    step();
    irq_i = '0;
    sync_i = 1; code_i = 4'd10;
    step();
    sync_i = 0;
    chk("R8 sync beats interrupt", {28'h0, cause_o[5:2]}, 32'd10);
    step();
    chk("R10 unserved after sync", {31'h0, cause_o[11]}, 32'h1);
  endtask

  initial begin
    idle();
    rst_n = 0;
    t_reset();
    t_sw_write();
    t_nested();
    t_push_beats_pop();
    t_latch_disabled();
    t_masked();
    t_service_handshake();
    t_sync_priority();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule